// File: doc/BRIEF.md
# Pixel Range Clamp and Depth Formatter

This stage sits at the end of an output pixel path, after color conversion. It receives pixels of three 12-bit components under a valid strobe. It can widen narrower source data to 12 bits, force each component into a limited video range, and cut the result to 6 or 8 significant bits per component. Each pixel passes through three steps in a fixed order: widening, then range limiting, then depth cutting. The result appears two clock cycles after the pixel enters.

Configuration is static. The mode inputs are expected to change only while no pixel is in flight. Software chooses widening only for full-range RGB output and leaves it off for limited-range RGB or YCbCr. The range limiter is steered by a format code. Three of its codes pick a preset range that follows the output depth. One code picks separate lower and upper bounds for each component. Software normally programs those bounds to 0x10 and 0xFEF for all three components.

Top module: `pix_range_fmt`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_pix` become 0 at that edge.
- R2: `out_valid` equals `in_valid` from two clock edges earlier, and each accepted pixel yields exactly one result two cycles later.
- R3: With `exp_en` = 0, each 12-bit component enters the range stage unchanged.
- R4: With `exp_en` = 1 and `exp_mode` = 1, the low 8 bits v of a component become {v, v[7:4]}, and the component's top 4 input bits are ignored.
- R5: With `exp_en` = 1 and `exp_mode` = 0, the low 10 bits v of a component become {v, v[9:8]}, and the component's top 2 input bits are ignored.
- R6: With `clamp_en` = 1 and `clamp_fmt` equal to 1 (8 bpc), 2 (10 bpc) or 3 (12 bpc), each component is limited to 16..235, 64..940 or 256..3760 at that depth, compared left-aligned to 12 bits. In all three cases this is the 12-bit range 256..3760.
- R7: With `clamp_en` = 1 and `clamp_fmt` = 7, each component is limited to its own bounds from `clamp_lo` and `clamp_hi`. A value below the lower bound becomes the lower bound. A value above the upper bound becomes the upper bound.
- R8: With `clamp_en` = 0, or with `clamp_fmt` equal to 0, 4, 5 or 6, no range limiting takes place.
- R9: With `trunc_en` = 1, `trunc_depth` = 0 clears the low 6 bits of every component, and `trunc_depth` = 1 clears the low 4 bits.
- R10: With `trunc_en` = 0, or with `trunc_depth` equal to 2 (10 bpc, unsupported) or 3, no bits are cleared.
- R11: Range limiting acts on the widened value and depth cutting acts on the limited value. For example, preset limiting with a 6-bit cut turns 4095 into 3712.
- R12: In a cycle with no valid result, `out_pix` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 36 | Input pixel: R in [35:24], G in [23:12], B in [11:0] |
| exp_en | input | 1 | Enable bit widening |
| exp_mode | input | 1 | 0: 10-bit source, 1: 8-bit source (value in the low bits of each component) |
| clamp_en | input | 1 | Enable range limiting |
| clamp_fmt | input | 3 | Range code: 0 none, 1 8 bpc, 2 10 bpc, 3 12 bpc, 7 programmable |
| clamp_lo | input | 36 | Programmable lower bounds, same component layout as in_pix |
| clamp_hi | input | 36 | Programmable upper bounds, same component layout as in_pix |
| trunc_en | input | 1 | Enable depth cutting |
| trunc_depth | input | 2 | 0: 6 bits per component, 1: 8 bits per component, 2 and 3: no cut |
| out_valid | output | 1 | Result qualifier |
| out_pix | output | 36 | Formatted pixel, same layout as in_pix |

## Verification
The assertions check on every cycle that results arrive two cycles after input, that reset empties the pipeline, and that held data does not move between results. They also check that cut components carry zeroed low bits, that preset limiting keeps every component inside 256..3760, and that programmable limiting keeps each component inside its own bounds. Exact output values cannot be shown by those properties. Only the bench scenarios show them: the bit replication of each widening mode, the inputs that are ignored, the codes that must not limit or cut, and the effect of the step order on a value. These scenarios sweep every configuration with edge and scattered values, and run one full 4096-value sweep through programmable bounds with an 8-bit cut.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  // range-limit format codes
  localparam logic [2:0] CLAMP_OFF  = 3'd0;
  localparam logic [2:0] CLAMP_8    = 3'd1;
  localparam logic [2:0] CLAMP_10   = 3'd2;
  localparam logic [2:0] CLAMP_12   = 3'd3;
  localparam logic [2:0] CLAMP_PROG = 3'd7;

  // depth-cut codes
  localparam logic [1:0] TRUNC_6 = 2'd0;
  localparam logic [1:0] TRUNC_8 = 2'd1;

  // widening source selection
  localparam logic EXP_FROM_10 = 1'b0;
  localparam logic EXP_FROM_8  = 1'b1;

  // video range limits at each native depth
  localparam int unsigned LIM8_LO  = 16;
  localparam int unsigned LIM8_HI  = 235;
  localparam int unsigned LIM10_LO = 64;
  localparam int unsigned LIM10_HI = 940;
  localparam int unsigned LIM12_LO = 256;
  localparam int unsigned LIM12_HI = 3760;
endpackage

// File: rtl/fmt_expand.sv
module fmt_expand #(
  parameter int unsigned CW = 12
) (
  input  logic [CW-1:0] din,
  input  logic          en,
  input  logic          mode,
  output logic [CW-1:0] dout
);
  import fmt_pkg::*;

  localparam int unsigned SW_A = 8;
  localparam int unsigned SW_B = 10;

  logic [CW-1:0] rep_a;
  logic [CW-1:0] rep_b;

  // bit k from the top takes source bit (k mod width) from the top
  for (genvar k = 0; k < CW; k++) begin : g_rep
    assign rep_a[CW-1-k] = din[SW_A-1-(k % SW_A)];
    assign rep_b[CW-1-k] = din[SW_B-1-(k % SW_B)];
  end

  always_comb begin
    if (!en)                    dout = din;
    else if (mode == EXP_FROM_8) dout = rep_a;
    else                        dout = rep_b;
  end
endmodule

// File: rtl/fmt_clamp.sv
module fmt_clamp #(
  parameter int unsigned CW = 12
) (
  input  logic [CW-1:0] din,
  input  logic          en,
  input  logic [2:0]    fmt,
  input  logic [CW-1:0] prog_lo,
  input  logic [CW-1:0] prog_hi,
  output logic [CW-1:0] dout
);
  import fmt_pkg::*;

  // presets left-aligned to the component width
  localparam logic [CW-1:0] P8_LO  = CW'(LIM8_LO  << (CW-8));
  localparam logic [CW-1:0] P8_HI  = CW'(LIM8_HI  << (CW-8));
  localparam logic [CW-1:0] P10_LO = CW'(LIM10_LO << (CW-10));
  localparam logic [CW-1:0] P10_HI = CW'(LIM10_HI << (CW-10));
  localparam logic [CW-1:0] P12_LO = CW'(LIM12_LO << (CW-12));
  localparam logic [CW-1:0] P12_HI = CW'(LIM12_HI << (CW-12));

  logic          active;
  logic [CW-1:0] lim_lo;
  logic [CW-1:0] lim_hi;

  always_comb begin
    active = en;
    lim_lo = '0;
    lim_hi = '1;
    case (fmt)
      CLAMP_8:    begin lim_lo = P8_LO;   lim_hi = P8_HI;   end
      CLAMP_10:   begin lim_lo = P10_LO;  lim_hi = P10_HI;  end
      CLAMP_12:   begin lim_lo = P12_LO;  lim_hi = P12_HI;  end
      CLAMP_PROG: begin lim_lo = prog_lo; lim_hi = prog_hi; end
      default:    active = 1'b0;
    endcase
  end

  always_comb begin
    if (!active)            dout = din;
    else if (din < lim_lo)  dout = lim_lo;
    else if (din > lim_hi)  dout = lim_hi;
    else                    dout = din;
  end
endmodule

// File: rtl/fmt_trunc.sv
module fmt_trunc #(
  parameter int unsigned CW = 12
) (
  input  logic [CW-1:0] din,
  input  logic          en,
  input  logic [1:0]    depth,
  output logic [CW-1:0] dout
);
  import fmt_pkg::*;

  localparam logic [CW-1:0] KEEP6 = {{6{1'b1}}, {(CW-6){1'b0}}};
  localparam logic [CW-1:0] KEEP8 = {{8{1'b1}}, {(CW-8){1'b0}}};

  always_comb begin
    dout = din;
    if (en) begin
      case (depth)
        TRUNC_6: dout = din & KEEP6;
        TRUNC_8: dout = din & KEEP8;
        default: dout = din;
      endcase
    end
  end
endmodule

// File: rtl/pix_range_fmt.sv
module pix_range_fmt #(
  parameter int unsigned CW = 12,
  parameter int unsigned NC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CW*NC-1:0] in_pix,
  input  logic             exp_en,
  input  logic             exp_mode,
  input  logic             clamp_en,
  input  logic [2:0]       clamp_fmt,
  input  logic [CW*NC-1:0] clamp_lo,
  input  logic [CW*NC-1:0] clamp_hi,
  input  logic             trunc_en,
  input  logic [1:0]       trunc_depth,
  output logic             out_valid,
  output logic [CW*NC-1:0] out_pix
);
  localparam int unsigned PW = CW * NC;

  logic [PW-1:0] wide_pix;
  logic [PW-1:0] lim_pix;
  logic [PW-1:0] s1_pix;
  logic          s1_valid;
  logic [PW-1:0] cut_pix;

  for (genvar c = 0; c < NC; c++) begin : g_comp
    fmt_expand #(.CW(CW)) u_expand (
      .din  (in_pix[c*CW +: CW]),
      .en   (exp_en),
      .mode (exp_mode),
      .dout (wide_pix[c*CW +: CW])
    );

    fmt_clamp #(.CW(CW)) u_clamp (
      .din     (wide_pix[c*CW +: CW]),
      .en      (clamp_en),
      .fmt     (clamp_fmt),
      .prog_lo (clamp_lo[c*CW +: CW]),
      .prog_hi (clamp_hi[c*CW +: CW]),
      .dout    (lim_pix[c*CW +: CW])
    );

    fmt_trunc #(.CW(CW)) u_trunc (
      .din   (s1_pix[c*CW +: CW]),
      .en    (trunc_en),
      .depth (trunc_depth),
      .dout  (cut_pix[c*CW +: CW])
    );
  end

  // stage 1: widened and range-limited
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_pix <= lim_pix;
    end
  end

  // stage 2: depth cut, registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_pix <= cut_pix;
    end
  end
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int unsigned CW = 12,
  parameter int unsigned NC = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             clamp_en,
  input logic [2:0]       clamp_fmt,
  input logic [CW*NC-1:0] clamp_lo,
  input logic [CW*NC-1:0] clamp_hi,
  input logic             trunc_en,
  input logic [1:0]       trunc_depth,
  input logic             out_valid,
  input logic [CW*NC-1:0] out_pix
);
  localparam logic [CW-1:0] PRE_LO = CW'(256 << (CW-12));
  localparam logic [CW-1:0] PRE_HI = CW'(3760 << (CW-12));

  logic cut_on;
  logic preset_on;
  assign cut_on    = trunc_en && (trunc_depth < 2'd2);
  assign preset_on = clamp_en && (clamp_fmt >= 3'd1) && (clamp_fmt <= 3'd3);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_pix == '0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 $stable(out_pix));

  for (genvar c = 0; c < NC; c++) begin : g_chk
    assert_cut6_R9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && trunc_en && trunc_depth == 2'd0)
        |-> (out_pix[c*CW +: (CW-6)] == '0));

    assert_cut8_R9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && trunc_en && trunc_depth == 2'd1)
        |-> (out_pix[c*CW +: (CW-8)] == '0));

    assert_preset_range_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && preset_on)
        |-> (out_pix[c*CW +: CW] >= PRE_LO && out_pix[c*CW +: CW] <= PRE_HI));

    assert_prog_range_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && clamp_en && clamp_fmt == 3'd7 && !cut_on &&
       clamp_lo[c*CW +: CW] <= clamp_hi[c*CW +: CW])
        |-> (out_pix[c*CW +: CW] >= clamp_lo[c*CW +: CW] &&
             out_pix[c*CW +: CW] <= clamp_hi[c*CW +: CW]));
  end
endmodule

bind pix_range_fmt fmt_checker #(.CW(CW), .NC(NC)) u_fmt_checker (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .clamp_en    (clamp_en),
  .clamp_fmt   (clamp_fmt),
  .clamp_lo    (clamp_lo),
  .clamp_hi    (clamp_hi),
  .trunc_en    (trunc_en),
  .trunc_depth (trunc_depth),
  .out_valid   (out_valid),
  .out_pix     (out_pix)
);

// File: tb/tb_pix_range_fmt.sv
module tb_pix_range_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int NC = 3;
  localparam int PW = CW * NC;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [PW-1:0] in_pix;
  logic          exp_en, exp_mode, clamp_en, trunc_en;
  logic [2:0]    clamp_fmt;
  logic [1:0]    trunc_depth;
  logic [PW-1:0] clamp_lo, clamp_hi;
  logic          out_valid;
  logic [PW-1:0] out_pix;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // two-deep history of driven pixels and their expected results
  logic          h0_v = 0, h1_v = 0;
  logic [PW-1:0] h0_e = '0, h1_e = '0;
  string         h0_t = "R12", h1_t = "R12";
  logic [PW-1:0] last_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_range_fmt #(.CW(CW), .NC(NC)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
    .exp_en(exp_en), .exp_mode(exp_mode), .clamp_en(clamp_en),
    .clamp_fmt(clamp_fmt), .clamp_lo(clamp_lo), .clamp_hi(clamp_hi),
    .trunc_en(trunc_en), .trunc_depth(trunc_depth),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  // arithmetic reference for one component
  function automatic logic [11:0] ref_comp(input logic [11:0] v, input logic [11:0] lo,
                                           input logic [11:0] hi);
    int x, l, h;
    bit lim;
    x = v;
    if (exp_en) begin
      if (exp_mode) x = (v[7:0] * 16) + (v[7:0] / 16);   // R4
      else          x = (v[9:0] * 4)  + (v[9:0] / 256);  // R5
    end
    lim = clamp_en;
    l = 0; h = 4095;
    case (clamp_fmt)
      3'd1: begin l = 16 * 16; h = 235 * 16; end
      3'd2: begin l = 64 * 4;  h = 940 * 4;  end
      3'd3: begin l = 256;     h = 3760;     end
      3'd7: begin l = lo;      h = hi;       end
      default: lim = 0;
    endcase
    if (lim) begin
      if (x < l) x = l;
      else if (x > h) x = h;
    end
    if (trunc_en && trunc_depth == 2'd0) x = (x / 64) * 64;
    if (trunc_en && trunc_depth == 2'd1) x = (x / 16) * 16;
    return 12'(x);
  endfunction

  function automatic string pick_tag();
    bit cut, lim;
    cut = trunc_en && trunc_depth < 2;
    lim = clamp_en && (clamp_fmt inside {3'd1, 3'd2, 3'd3, 3'd7});
    if (trunc_en && !cut) return "R10";
    if (cut && lim)       return "R11";
    if (cut)              return "R9";
    if (clamp_en && !lim) return "R8";
    if (lim && clamp_fmt == 3'd7) return "R7";
    if (lim)              return "R6";
    if (exp_en && exp_mode)  return "R4";
    if (exp_en)           return "R5";
    return "R3";
  endfunction

  // one negedge step: check result of the pixel driven two steps ago, then drive
  task automatic step(input logic v, input logic [PW-1:0] p);
    logic [PW-1:0] e;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== h1_v) begin
      n_bad++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, h1_v);
    end else if (h1_v && out_pix !== h1_e) begin
      n_bad++;
      $display("FAIL %s out_pix actual=%h expected=%h", h1_t, out_pix, h1_e);
    end else if (!h1_v && out_pix !== last_out) begin
      n_bad++;
      $display("FAIL R12 out_pix actual=%h expected=%h", out_pix, last_out);
    end
    if (h1_v) last_out = h1_e;
    for (int c = 0; c < NC; c++)
      e[c*CW +: CW] = ref_comp(p[c*CW +: CW], clamp_lo[c*CW +: CW], clamp_hi[c*CW +: CW]);
    h1_v = h0_v; h1_e = h0_e; h1_t = h0_t;
    h0_v = v;    h0_e = e;    h0_t = v ? pick_tag() : "R12";
    in_valid = v;
    in_pix   = p;
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) step(1'b0, '0);
  endtask

  function automatic logic [11:0] gen_val(input int k, input int c, input int cfg);
    case ((k + c) % 8)
      0: gen_val = 12'd0;
      1: gen_val = 12'd15;
      2: gen_val = 12'd255;
      3: gen_val = 12'd256;
      4: gen_val = 12'd1023;
      5: gen_val = 12'd3760;
      6: gen_val = 12'd3761;
      default: gen_val = 12'd4095;
    endcase
    if (k >= 8) gen_val = 12'((k * 1237 + c * 733 + cfg * 97) % 4096);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cfg;
    logic [PW-1:0] p;
    rst = 1; in_valid = 0; in_pix = '0;
    exp_en = 0; exp_mode = 0; clamp_en = 0; clamp_fmt = 0;
    trunc_en = 0; trunc_depth = 0;
    clamp_lo = {12'h010, 12'h100, 12'h050};
    clamp_hi = {12'hFEF, 12'hC00, 12'h7FF};
    in_pix = {PW{1'b1}}; in_valid = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state even with a valid pixel presented
    n_cmp++;
    if (out_valid !== 1'b0 || out_pix !== '0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%0b/%h expected=0/0", out_valid, out_pix);
    end
    in_valid = 0; in_pix = '0;
    rst = 0;

    // configuration sweep
    cfg = 0;
    for (int e = 0; e < 3; e++)
      for (int ce = 0; ce < 2; ce++)
        for (int f = 0; f < 8; f++)
          for (int te = 0; te < 2; te++)
            for (int d = 0; d < 4; d++) begin
              exp_en = (e != 0); exp_mode = (e == 2);
              clamp_en = ce[0]; clamp_fmt = f[2:0];
              trunc_en = te[0]; trunc_depth = d[1:0];
              for (int k = 0; k < 12; k++) begin
                for (int c = 0; c < NC; c++) p[c*CW +: CW] = gen_val(k, c, cfg);
                step(1'b1, p);
                if (k == 5) step(1'b0, '0);   // R12 gap inside a stream
              end
              drain();
              cfg++;
            end

    // full sweep through programmable bounds with an 8-bit cut (R7, R11)
    exp_en = 0; exp_mode = 0; clamp_en = 1; clamp_fmt = 3'd7;
    trunc_en = 1; trunc_depth = 2'd1;
    clamp_lo = {12'd100, 12'd500, 12'd0};
    clamp_hi = {12'd3000, 12'd4095, 12'd2047};
    for (int i = 0; i < 4096; i++) begin
      p = {12'(i), 12'(4095 - i), 12'(i ^ 12'hA5A)};
      step(1'b1, p);
    end
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule